// File: doc/BRIEF.md
# Shared Host-Channel Request Queue with Channel Halt

This block collects transaction requests from several host channels into one bounded, ordered queue and hands them one at a time to a transaction engine. Each channel that software has enabled can offer a request (with a one-bit direction) on its own post port. A round-robin arbiter admits at most one post per cycle into the tail of the queue. The head request is offered to the engine on a valid/ready stream. The engine then reports the end of that bus transaction with a single done pulse, and it accepts nothing new until that pulse.

Software controls each channel through a control write that carries a channel index, an enable bit and a disable bit. A disable without enable purges only that channel's queued requests. A disable together with enable starts a halt. The channel's queued requests are purged, and when the channel next wins arbitration and a slot is free, a halt marker is placed in the queue. The marker is never shown to the engine. When it reaches the head, and no engine transaction of that channel is still running, it is retired internally. Retiring it raises that channel's sticky halted flag and drops its enable.

Back-pressure rules for the engine stream: `txn_valid` is low whenever the engine has an unfinished transaction. A head request stays valid, with unchanged channel and direction, until `txn_ready` is seen high. The one exception is a purge of that head's own channel, which may withdraw it. On the post side, `post_ready[c]` may depend on `post_valid[c]` in the same cycle. A post is accepted in a cycle where both are high.

Top module: `hcq_top`

## Requirements
- R1: A control write with disable=1 and enable=1 starts a halt. Once the channel's marker is retired from the head, `halted_irq` for that channel reads 1 and `chan_en` for that channel reads 0 from the next cycle.
- R2: A control write with disable=1 and enable=0 leaves the channel's enable and halted flag unchanged, and it queues no marker.
- R3: A control write with disable=1 removes, in that same cycle, every queued entry of the named channel, while entries of other channels keep their relative order. Occupancy never exceeds DEPTH.
- R4: A halt marker is written only on the halting channel's arbitration win. When the queue holds DEPTH entries, no post and no marker is accepted, but a purge still takes effect.
- R5: While the engine has an unfinished transaction of a halting channel, that channel's marker stays at the head and its halted flag is not raised.
- R6: `halted_irq[c]` stays 1 until a cycle with `halt_clr[c]`=1 clears it. If the flag is set and cleared in the same cycle, setting wins.
- R7: Arbitration is round-robin. The search starts at the channel after the last winner (channel 0 after reset), and at most one entry is written per cycle.
- R8: `txn_valid` is 1 exactly when the head entry is a request and no engine transaction is unfinished. An entry leaves on `txn_valid`&&`txn_ready`. The transaction stays unfinished until a `txn_done` pulse, and halt markers are never presented.
- R9: `post_ready[c]` is 1 only for an enabled channel with no halt pending. While a halt is pending, writes with disable=0 to that channel are ignored.
- R10: After reset the queue is empty, every channel is disabled, no flag is set and no transaction is unfinished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_ch | input | CHW | Channel index of the control write |
| ctl_en | input | 1 | Enable bit of the control write |
| ctl_dis | input | 1 | Disable bit of the control write |
| halt_clr | input | NCH | Write-one-to-clear for the halted flags |
| post_valid | input | NCH | Per-channel request offer |
| post_dir | input | NCH | Per-channel request direction |
| post_ready | output | NCH | Per-channel request accepted |
| txn_valid | output | 1 | Head request offered to the engine |
| txn_ready | input | 1 | Engine takes the head request |
| txn_ch | output | CHW | Channel of the offered request |
| txn_dir | output | 1 | Direction of the offered request |
| txn_done | input | 1 | Engine finished its current transaction |
| chan_en | output | NCH | Channel enable state |
| halted_irq | output | NCH | Sticky per-channel halted flag |

## Verification
A compaction fault, such as a lost, duplicated or reordered survivor, shows up as a wrong `txn_ch` or `txn_dir` the next time that slot reaches the head. That can take up to DEPTH engine transactions. A wrong arbitration pointer changes which `post_ready` bit rises in the very cycle of the next contested post. A stale marker flag or an unfinished-transaction flag shows up as a halted flag that rises one or more cycles early or never rises. Because the reference model is compared on every cycle, each of these faults is reported in the first cycle its effect reaches a port.

// File: rtl/hcq_pkg.sv
package hcq_pkg;

  typedef enum logic {
    REQ_XFER = 1'b0,
    REQ_HALT = 1'b1
  } req_kind_e;

  typedef struct packed {
    req_kind_e kind;
    logic      dir;
  } req_attr_t;

endpackage

// File: rtl/hcq_rr.sv
module hcq_rr #(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic           allow,
  output logic [NCH-1:0] grant,
  output logic [CHW-1:0] grant_idx
);

  logic [CHW-1:0] ptr;

  always_comb begin
    logic found;
    logic [CHW-1:0] idx;
    grant     = '0;
    grant_idx = '0;
    found     = 1'b0;
    for (int k = 0; k < NCH; k++) begin
      idx = CHW'((int'(ptr) + k) % NCH);
      if (allow && !found && req[idx]) begin
        found      = 1'b1;
        grant[idx] = 1'b1;
        grant_idx  = idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (|grant) begin
      ptr <= (int'(grant_idx) == NCH - 1) ? '0 : grant_idx + 1'b1;
    end
  end

  assert_one_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_grant_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);

endmodule

// File: rtl/hcq_store.sv
module hcq_store import hcq_pkg::*; #(
  parameter int NCH   = 4,
  parameter int DEPTH = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW  = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pop,
  input  logic           flush,
  input  logic [CHW-1:0] flush_ch,
  input  logic           wr_en,
  input  logic [CHW-1:0] wr_ch,
  input  req_attr_t      wr_attr,
  output logic [CHW-1:0] head_ch,
  output req_attr_t      head_attr,
  output logic [CW-1:0]  count
);

  logic [CHW-1:0] q_ch [DEPTH];
  req_attr_t      q_at [DEPTH];
  logic [CHW-1:0] n_ch [DEPTH];
  req_attr_t      n_at [DEPTH];
  logic [CW-1:0]  n_cnt;

  // one-cycle compaction: survivors slide down in order, then the new entry lands
  always_comb begin
    int pos;
    pos = 0;
    for (int i = 0; i < DEPTH; i++) begin
      n_ch[i] = q_ch[i];
      n_at[i] = q_at[i];
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (i < int'(count) && !(pop && i == 0) && !(flush && q_ch[i] == flush_ch)) begin
        n_ch[AW'(pos)] = q_ch[i];
        n_at[AW'(pos)] = q_at[i];
        pos = pos + 1;
      end
    end
    if (wr_en && pos < DEPTH) begin
      n_ch[AW'(pos)] = wr_ch;
      n_at[AW'(pos)] = wr_attr;
      pos = pos + 1;
    end
    n_cnt = CW'(pos);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        q_ch[i] <= '0;
        q_at[i] <= '{kind: REQ_XFER, dir: 1'b0};
      end
    end else begin
      count <= n_cnt;
      for (int i = 0; i < DEPTH; i++) begin
        q_ch[i] <= n_ch[i];
        q_at[i] <= n_at[i];
      end
    end
  end

  assign head_ch   = q_ch[0];
  assign head_attr = q_at[0];

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  assert_full_blocks_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> int'(count) < DEPTH);

  for (genvar g = 0; g < DEPTH; g++) begin : g_purge_chk
    assert_flush_purged_R3: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !(g < int'(count) && q_ch[g] == $past(flush_ch)));
  end

endmodule

// File: rtl/hcq_chan_slot.sv
module hcq_chan_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wr_en_bit,
  input  logic wr_dis_bit,
  input  logic done,
  input  logic marker_sent,
  input  logic clr,
  output logic en,
  output logic halt_pend,
  output logic mk_queued,
  output logic halted
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en        <= 1'b0;
      halt_pend <= 1'b0;
      mk_queued <= 1'b0;
    end else if (wr && wr_dis_bit && wr_en_bit) begin
      halt_pend <= 1'b1;
      mk_queued <= 1'b0;
    end else if (done) begin
      halt_pend <= 1'b0;
      en        <= 1'b0;
      mk_queued <= 1'b0;
    end else begin
      if (wr && !wr_dis_bit && !halt_pend) en <= wr_en_bit;
      if (wr && wr_dis_bit)     mk_queued <= 1'b0;
      else if (marker_sent)     mk_queued <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    halted <= 1'b0;
    else if (done) halted <= 1'b1;
    else if (clr)  halted <= 1'b0;
  end

  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !clr |=> halted);

  assert_halt_drops_en_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) && !halt_pend |-> !en);

  assert_marker_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mk_queued |-> halt_pend);

endmodule

// File: rtl/hcq_top.sv
module hcq_top import hcq_pkg::*; #(
  parameter int NCH   = 4,
  parameter int DEPTH = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int CW  = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctl_wr,
  input  logic [CHW-1:0] ctl_ch,
  input  logic           ctl_en,
  input  logic           ctl_dis,
  input  logic [NCH-1:0] halt_clr,
  input  logic [NCH-1:0] post_valid,
  input  logic [NCH-1:0] post_dir,
  output logic [NCH-1:0] post_ready,
  output logic           txn_valid,
  input  logic           txn_ready,
  output logic [CHW-1:0] txn_ch,
  output logic           txn_dir,
  input  logic           txn_done,
  output logic [NCH-1:0] chan_en,
  output logic [NCH-1:0] halted_irq
);

  logic           flush;
  logic [CHW-1:0] head_ch;
  req_attr_t      head_at;
  logic [CW-1:0]  cnt;
  logic           busy;
  logic [CHW-1:0] busy_ch;
  logic           head_live, fire, mk_ret, pop;
  logic [NCH-1:0] hp_v, mq_v, done_v, req, grant;
  logic [CHW-1:0] gidx;
  req_attr_t      wr_attr;

  assign flush     = ctl_wr && ctl_dis;
  assign head_live = cnt != '0;
  assign txn_valid = head_live && head_at.kind == REQ_XFER && !busy;
  assign fire      = txn_valid && txn_ready;
  assign mk_ret    = head_live && head_at.kind == REQ_HALT && !(busy && busy_ch == head_ch);
  assign pop       = fire || mk_ret;
  assign txn_ch    = head_ch;
  assign txn_dir   = head_at.dir;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic hit;
    assign hit = ctl_ch == CHW'(c);
    assign req[c] = !(flush && hit) &&
                    ((post_valid[c] && chan_en[c] && !hp_v[c]) || (hp_v[c] && !mq_v[c]));
    assign done_v[c]     = mk_ret && head_ch == CHW'(c);
    assign post_ready[c] = grant[c] && !hp_v[c];

    hcq_chan_slot u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (ctl_wr && hit),
      .wr_en_bit  (ctl_en),
      .wr_dis_bit (ctl_dis),
      .done       (done_v[c]),
      .marker_sent(grant[c] && hp_v[c]),
      .clr        (halt_clr[c]),
      .en         (chan_en[c]),
      .halt_pend  (hp_v[c]),
      .mk_queued  (mq_v[c]),
      .halted     (halted_irq[c])
    );

    assert_post_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      post_ready[c] |-> chan_en[c] && !hp_v[c]);

    assert_halt_after_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halted_irq[c]) |-> $past(!(busy && busy_ch == CHW'(c))));
  end

  hcq_rr #(.NCH(NCH)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .allow    (int'(cnt) < DEPTH),
    .grant    (grant),
    .grant_idx(gidx)
  );

  assign wr_attr.kind = hp_v[gidx] ? REQ_HALT : REQ_XFER;
  assign wr_attr.dir  = hp_v[gidx] ? 1'b0 : post_dir[gidx];

  hcq_store #(.NCH(NCH), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .pop      (pop),
    .flush    (flush),
    .flush_ch (ctl_ch),
    .wr_en    (|grant),
    .wr_ch    (gidx),
    .wr_attr  (wr_attr),
    .head_ch  (head_ch),
    .head_attr(head_at),
    .count    (cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      busy_ch <= '0;
    end else if (fire) begin
      busy    <= 1'b1;
      busy_ch <= head_ch;
    end else if (txn_done) begin
      busy    <= 1'b0;
    end
  end

  assert_hold_head_R8: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !txn_ready && !(flush && ctl_ch == txn_ch)
      |=> txn_valid && $stable(txn_ch) && $stable(txn_dir));

  assert_idle_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !txn_valid);

endmodule

// File: tb/hcq_top_tb.sv
`timescale 1ns/1ps
module hcq_top_tb;
  localparam int N = 4;
  localparam int D = 8;
  localparam int CHW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 0, ctl_en = 0, ctl_dis = 0;
  logic [CHW-1:0] ctl_ch = '0;
  logic [N-1:0] halt_clr = '0, post_valid = '0, post_dir = '0;
  logic txn_ready = 0, txn_done = 0;
  logic [N-1:0] post_ready, chan_en, halted_irq;
  logic txn_valid, txn_dir;
  logic [CHW-1:0] txn_ch;

  always #5 clk = ~clk;

  hcq_top #(.NCH(N), .DEPTH(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_ch(ctl_ch), .ctl_en(ctl_en),
    .ctl_dis(ctl_dis), .halt_clr(halt_clr), .post_valid(post_valid), .post_dir(post_dir),
    .post_ready(post_ready), .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_ch(txn_ch),
    .txn_dir(txn_dir), .txn_done(txn_done), .chan_en(chan_en), .halted_irq(halted_irq)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  typedef struct { int ch; bit hlt; bit dir; } ment_t;
  ment_t qm[$];
  bit m_en[N], m_hp[N], m_mk[N], m_hl[N];
  bit m_busy;
  int m_bch, m_ptr;
  bit e_tv, e_fire, e_ret;
  int e_win;

  task automatic model_reset();
    qm.delete();
    for (int c = 0; c < N; c++) begin m_en[c] = 0; m_hp[c] = 0; m_mk[c] = 0; m_hl[c] = 0; end
    m_busy = 0; m_bch = 0; m_ptr = 0;
  endtask

  task automatic model_eval_and_compare();
    bit fl;
    bit rq[N];
    fl = ctl_wr && ctl_dis;
    e_tv = qm.size() > 0 && !qm[0].hlt && !m_busy;
    e_fire = e_tv && txn_ready;
    e_ret = qm.size() > 0 && qm[0].hlt && !(m_busy && m_bch == qm[0].ch);
    for (int c = 0; c < N; c++)
      rq[c] = !(fl && int'(ctl_ch) == c) &&
              ((post_valid[c] && m_en[c] && !m_hp[c]) || (m_hp[c] && !m_mk[c]));
    e_win = -1;
    if (qm.size() < D)
      for (int k = 0; k < N; k++)
        if (e_win < 0 && rq[(m_ptr + k) % N]) e_win = (m_ptr + k) % N;
    chk("R8 txn_valid", int'(txn_valid), int'(e_tv));
    if (e_tv) begin
      chk("R8 txn_ch", int'(txn_ch), qm[0].ch);
      chk("R8 txn_dir", int'(txn_dir), int'(qm[0].dir));
    end
    for (int c = 0; c < N; c++) begin
      chk("R7 post_ready", int'(post_ready[c]), int'(e_win == c && !m_hp[c]));
      chk("R9 chan_en", int'(chan_en[c]), int'(m_en[c]));
      chk("R6 halted_irq", int'(halted_irq[c]), int'(m_hl[c]));
    end
  endtask

  task automatic model_update();
    ment_t nq[$];
    bit fl, wr_c, done;
    fl = ctl_wr && ctl_dis;
    for (int i = 0; i < qm.size(); i++)
      if (!((e_fire || e_ret) && i == 0) && !(fl && qm[i].ch == int'(ctl_ch))) nq.push_back(qm[i]);
    if (e_win >= 0) begin
      ment_t e;
      e.ch = e_win; e.hlt = m_hp[e_win]; e.dir = m_hp[e_win] ? 1'b0 : post_dir[e_win];
      nq.push_back(e);
      m_ptr = (e_win + 1) % N;
    end
    for (int c = 0; c < N; c++) begin
      wr_c = ctl_wr && int'(ctl_ch) == c;
      done = e_ret && qm[0].ch == c;
      if (done) m_hl[c] = 1; else if (halt_clr[c]) m_hl[c] = 0;
      if (wr_c && ctl_dis && ctl_en) begin m_hp[c] = 1; m_mk[c] = 0; end
      else if (done) begin m_hp[c] = 0; m_en[c] = 0; m_mk[c] = 0; end
      else begin
        if (wr_c && !ctl_dis && !m_hp[c]) m_en[c] = ctl_en;
        if (wr_c && ctl_dis) m_mk[c] = 0;
        else if (e_win == c && m_hp[c]) m_mk[c] = 1;
      end
    end
    if (e_fire) begin m_busy = 1; m_bch = qm[0].ch; end
    else if (txn_done) m_busy = 0;
    qm = nq;
  endtask

  // one clock: compare mid-cycle, update model at the edge, return at the next negedge
  task automatic cyc();
    #1;
    model_eval_and_compare();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic ctl(int ch, bit en, bit dis);
    ctl_wr = 1; ctl_ch = CHW'(ch); ctl_en = en; ctl_dis = dis;
    cyc();
    ctl_wr = 0; ctl_en = 0; ctl_dis = 0;
  endtask

  initial begin : watchdog
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int got[$];
    int exp_order[6] = '{0, 2, 3, 0, 2, 3};
    model_reset();
    post_valid = '1;
    repeat (3) @(negedge clk);
    #1;
    chk("R10 reset txn_valid", int'(txn_valid), 0);
    chk("R10 reset chan_en", int'(chan_en), 0);
    chk("R10 reset halted_irq", int'(halted_irq), 0);
    chk("R10 reset post_ready", int'(post_ready), 0);
    @(negedge clk);
    post_valid = '0;
    rst_n = 1;

    for (int c = 0; c < N; c++) ctl(c, 1, 0);
    #1 chk("R9 all enabled", int'(chan_en), 15);

    // round-robin fill of a full queue
    post_valid = '1; post_dir = 4'b1010;
    for (int k = 0; k < D; k++) begin
      #1 chk("R7 rotating grant", int'(post_ready), 1 << (k % N));
      cyc();
    end
    #1 chk("R4 full blocks posts", int'(post_ready), 0);
    post_valid = '0;
    cyc();

    // purge-only on a full queue
    ctl(1, 0, 1);
    #1;
    chk("R2 enable kept", int'(chan_en[1]), 1);
    chk("R2 no halted flag", int'(halted_irq), 0);
    txn_ready = 1; txn_done = 1;
    for (int k = 0; k < 20; k++) begin
      #1 if (txn_valid) got.push_back(int'(txn_ch));
      cyc();
    end
    chk("R3 survivor count", got.size(), 6);
    for (int i = 0; i < 6 && i < got.size(); i++) chk("R3 survivor order", got[i], exp_order[i]);
    txn_ready = 0; txn_done = 0;

    // halt with a transaction still on the bus
    post_valid = 4'b0100; post_dir = 4'b0100;
    repeat (3) cyc();
    post_valid = '0;
    txn_ready = 1; cyc(); txn_ready = 0;
    ctl(2, 1, 1);
    repeat (5) cyc();
    #1;
    chk("R5 no flag while busy", int'(halted_irq[2]), 0);
    chk("R5 still enabled", int'(chan_en[2]), 1);
    chk("R8 marker hidden", int'(txn_valid), 0);
    ctl(2, 0, 0);
    post_valid = 4'b0100;
    #1;
    chk("R9 write ignored", int'(chan_en[2]), 1);
    chk("R9 no post while halting", int'(post_ready[2]), 0);
    post_valid = '0;
    txn_done = 1; cyc(); txn_done = 0;
    repeat (3) cyc();
    #1;
    chk("R1 halted flag", int'(halted_irq[2]), 1);
    chk("R1 enable dropped", int'(chan_en[2]), 0);
    repeat (3) cyc();
    #1 chk("R6 sticky", int'(halted_irq[2]), 1);
    halt_clr = 4'b0100; cyc(); halt_clr = '0;
    #1 chk("R6 cleared", int'(halted_irq[2]), 0);

    // mixed random traffic against the model
    for (int k = 0; k < 4000; k++) begin
      post_valid = N'($urandom);
      post_dir   = N'($urandom);
      txn_ready  = ($urandom % 2) == 0;
      txn_done   = ($urandom % 3) == 0;
      halt_clr   = (($urandom % 8) == 0) ? N'($urandom) : '0;
      ctl_wr     = ($urandom % 8) == 0;
      ctl_ch     = CHW'($urandom);
      ctl_en     = ($urandom % 4) != 0;
      ctl_dis    = ($urandom % 4) == 0;
      cyc();
    end
    ctl_wr = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule